// File: doc/BRIEF.md
# Iterative Bit Extract and Deposit Unit

This functional unit gathers or scatters the bits of a source word under the control of a selector mask, and it can also clear every bit of a source at or above a given position. A compact bit-walking engine sits behind a start/busy/done handshake. On each clock it takes the lowest set bit of the remaining mask, moves one bit between the source and the result, and then clears that mask bit. The number of walking cycles therefore equals the number of set mask bits, and the hardware stays small instead of using a log-depth network.

The caller presents an opcode, a source, a mask (or a bit index) and a narrow-mode flag, then pulses `start` while the unit is idle. The operands are copied in, so the caller's source values are never changed. The result is written to its own output and stays there until the next accepted start. Narrow mode treats the operands as half-width words.

Top module: `bxd_unit`

## Requirements
- R1: With opcode 0 (extract), the source bits found at the positions where the mask has a 1 are packed into the result upward from bit 0, keeping their order. All higher result bits are 0.
- R2: With opcode 1 (deposit), the source bits taken from bit 0 upward are placed, in order, into the result positions where the mask has a 1. All other result bits are 0.
- R3: With opcode 2 (zero-high), the result equals the source with every bit at or above the index cleared. The index is the value of `maskIn` bits 7:0.
- R4: For zero-high, an index at or above the operand width returns the source unchanged. Mask bits above bit 7 have no effect.
- R5: Take the rising edge that samples an accepted start as edge 0. For extract and deposit with N set (effective) mask bits, N ≥ 1, `done` is high for one cycle after edge N and `busy` is high after edges 0 to N−1. `busy` and `done` are never high together.
- R6: An extract or deposit with an all-zero effective mask, a zero-high, and opcode 3 all return their result with `done` high right after edge 0 and `busy` never set. For the zero-mask case and opcode 3 the result is 0.
- R7: When `narrow` is 1, the upper half of the source and of the mask has no effect, the operation uses the half width (including the width limit in R4), and the upper half of the result is 0.
- R8: A start while `busy` is high is ignored. The result output does not change between one accepted start and the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an operation (accepted only when idle) |
| opcode | input | 2 | 0 extract, 1 deposit, 2 zero-high, 3 returns zero |
| narrow | input | 1 | Half-width operand mode |
| srcIn | input | DATA_W | Source operand |
| maskIn | input | DATA_W | Selector mask, or bit index in bits 7:0 for zero-high |
| busy | output | 1 | Mask walk in progress |
| done | output | 1 | One-cycle pulse: result is valid |
| result | output | DATA_W | Result, held until the next accepted start |

## Verification
An 8-bit instance is driven with every one of the 256 masks against a spread of sources, at full width and in narrow mode, for both extract and deposit. The empty mask, single-bit masks and the full mask separate the quick path from walks of every length, and each result and latency is compared with a position-scanning reference. Zero-high is swept over all 256 index values, so indices below, at and above each width are all covered. A 64-bit instance is given directed cases: scattered masks, a full-width walk, garbage in the upper halves during narrow mode, and an index with high mask bits set. A start raised in the middle of a walk shows whether the unit ignores it and keeps its result.

// File: rtl/bxd_pkg.sv
package bxd_pkg;

  typedef enum logic [1:0] {
    OP_EXTRACT = 2'd0,
    OP_DEPOSIT = 2'd1,
    OP_ZHIGH   = 2'd2,
    OP_NONE    = 2'd3
  } bxdOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } bxdStrobe_t;

endpackage

// File: rtl/bxd_ctrl.sv
module bxd_ctrl
  import bxd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       loadQuick,
  input  logic       lastBit,
  output bxdStrobe_t strb,
  output logic       busy,
  output logic       done
);

  logic busyReg;
  logic doneReg;

  always_comb begin
    strb.load = start && !busyReg;
    strb.step = busyReg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyReg <= 1'b0;
      doneReg <= 1'b0;
    end else if (strb.load) begin
      busyReg <= !loadQuick;
      doneReg <= loadQuick;
    end else if (busyReg) begin
      busyReg <= !lastBit;
      doneReg <= lastBit;
    end else begin
      doneReg <= 1'b0;
    end
  end

  assign busy = busyReg;
  assign done = doneReg;

  // R5: walking and completion never overlap
  a_r5_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    busyReg |-> !doneReg);

  // R8: completion only follows an accepted start or a walk
  a_r8_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    doneReg |-> $past(busyReg || start));

endmodule

// File: rtl/bxd_datapath.sv
module bxd_datapath
  import bxd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bxdStrobe_t        strb,
  input  logic [1:0]        opIn,
  input  logic              narrowIn,
  input  logic [DATA_W-1:0] srcIn,
  input  logic [DATA_W-1:0] maskIn,
  output logic              loadQuick,
  output logic              lastBit,
  output logic [DATA_W-1:0] result
);

  localparam int HALF_W = DATA_W / 2;

  bxdOp_e opNew, opReg;
  logic narrowReg;
  logic [DATA_W-1:0] keepMask, effSrc, effMask, lowOnes, zhRes;
  logic [DATA_W-1:0] srcReg, maskReg, bitSel, lowBit, maskDrop, resReg;
  logic walkNew;
  int   idxVal;

  always_comb begin
    opNew    = bxdOp_e'(opIn);
    keepMask = narrowIn ? {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}} : {DATA_W{1'b1}};
    effSrc   = srcIn & keepMask;
    effMask  = maskIn & keepMask;
    idxVal   = int'(maskIn[IDX_W-1:0]);
    walkNew  = (opNew == OP_EXTRACT) || (opNew == OP_DEPOSIT);
    loadQuick = !walkNew || (effMask == '0);
  end

  // ones below the index; indices past the width keep every bit
  for (genvar g = 0; g < DATA_W; g++) begin : gLowOnes
    assign lowOnes[g] = (g < idxVal);
  end
  assign zhRes = effSrc & lowOnes;

  always_comb begin
    lowBit   = maskReg & (-maskReg);
    maskDrop = maskReg & (maskReg - DATA_W'(1));
    lastBit  = (maskDrop == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srcReg    <= '0;
      maskReg   <= '0;
      bitSel    <= '0;
      resReg    <= '0;
      opReg     <= OP_NONE;
      narrowReg <= 1'b0;
    end else if (strb.load) begin
      srcReg    <= effSrc;
      maskReg   <= walkNew ? effMask : '0;
      bitSel    <= DATA_W'(1);
      opReg     <= opNew;
      narrowReg <= narrowIn;
      resReg    <= (opNew == OP_ZHIGH) ? zhRes : '0;
    end else if (strb.step) begin
      maskReg <= maskDrop;
      bitSel  <= bitSel << 1;
      if (opReg == OP_EXTRACT && (srcReg & lowBit) != '0)
        resReg <= resReg | bitSel;
      else if (opReg == OP_DEPOSIT && (srcReg & bitSel) != '0)
        resReg <= resReg | lowBit;
    end
  end

  assign result = resReg;

  // R8: result moves only on a load or a walk step
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.load && !strb.step) |=> $stable(resReg));

  // R5: each walk step retires exactly one mask bit
  a_r5_one_bit_per_step: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.step && maskReg != '0) |=> ($countones(maskReg) == $countones($past(maskReg)) - 1));

  // R7: narrow operations never reach the upper half
  a_r7_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    narrowReg |-> (resReg[DATA_W-1:HALF_W] == '0));

  // R5: running position stays one-hot or empty
  a_r5_bitsel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bitSel));

endmodule

// File: rtl/bxd_unit.sv
module bxd_unit
  import bxd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        opcode,
  input  logic              narrow,
  input  logic [DATA_W-1:0] srcIn,
  input  logic [DATA_W-1:0] maskIn,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);

  bxdStrobe_t strb;
  logic loadQuick;
  logic lastBit;

  bxd_ctrl uCtrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .loadQuick (loadQuick),
    .lastBit   (lastBit),
    .strb      (strb),
    .busy      (busy),
    .done      (done)
  );

  bxd_datapath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) uPath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .opIn      (opcode),
    .narrowIn  (narrow),
    .srcIn     (srcIn),
    .maskIn    (maskIn),
    .loadQuick (loadQuick),
    .lastBit   (lastBit),
    .result    (result)
  );

endmodule

// File: tb/tb_bxd_unit.sv
module tb_bxd_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic startS = 1'b0, startW = 1'b0;
  logic [1:0] opcode = '0;
  logic narrow = 1'b0;
  logic [63:0] srcIn = '0, maskIn = '0;
  logic busyS, doneS, busyW, doneW;
  logic [7:0]  resS;
  logic [63:0] resW;

  int errors = 0;
  int checks = 0;

  bxd_unit #(.DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .start(startS), .opcode(opcode), .narrow(narrow),
    .srcIn(srcIn[7:0]), .maskIn(maskIn[7:0]),
    .busy(busyS), .done(doneS), .result(resS)
  );

  bxd_unit #(.DATA_W(64)) dutWide (
    .clk(clk), .rst_n(rst_n), .start(startW), .opcode(opcode), .narrow(narrow),
    .srcIn(srcIn), .maskIn(maskIn),
    .busy(busyW), .done(doneW), .result(resW)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference: scans bit positions in order
  function automatic logic [63:0] refOp(int op, bit nar, logic [63:0] s, logic [63:0] m, int w);
    int ww = nar ? w / 2 : w;
    int k = 0;
    int idx = int'(m[7:0]);
    logic [63:0] r = '0;
    for (int i = 0; i < ww; i++) begin
      if (op == 0 && m[i]) begin r[k] = s[i]; k++; end
      else if (op == 1 && m[i]) begin r[i] = s[k]; k++; end
      else if (op == 2 && i < idx) r[i] = s[i];
    end
    return r;
  endfunction

  function automatic int refLat(int op, bit nar, logic [63:0] m, int w);
    int ww = nar ? w / 2 : w;
    int n = 0;
    if (op > 1) return 1;
    for (int i = 0; i < ww; i++) if (m[i]) n++;
    return n + 1;
  endfunction

  task automatic runOp(input int op, input bit nar, input logic [63:0] s, input logic [63:0] m,
                       input bit wide, input string tag);
    int lat;
    int w = wide ? 64 : 8;
    logic [63:0] exp, act;
    int expLat;
    @(negedge clk);
    opcode = op[1:0]; narrow = nar; srcIn = s; maskIn = m;
    if (wide) startW = 1'b1; else startS = 1'b1;
    @(negedge clk);
    startS = 1'b0; startW = 1'b0;
    lat = 1;
    while (!(wide ? doneW : doneS) && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    act = wide ? resW : {56'd0, resS};
    exp = refOp(op, nar, s, m, w);
    expLat = refLat(op, nar, m, w);
    check(act == exp, tag, act, exp);
    check(lat == expLat, (expLat == 1) ? "R6 latency" : "R5 latency", 64'(lat), 64'(expLat));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] srcSet [8];
    logic [63:0] held;
    int lat;
    srcSet = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C, 8'h81, 8'h17, 8'hE8};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    check(!busyS && !doneS && resS == 0, "R5 reset state", {busyS, doneS, resS}, 64'd0);

    // R1 R2 full-width sweep of every mask
    for (int m = 0; m < 256; m++)
      for (int s = 0; s < 8; s++) begin
        runOp(0, 1'b0, 64'(srcSet[s]), 64'(m), 1'b0, "R1 extract");
        runOp(1, 1'b0, 64'(srcSet[s]), 64'(m), 1'b0, "R2 deposit");
      end
    // R7 narrow sweep, upper half of operands carries junk
    for (int m = 0; m < 256; m++)
      for (int s = 0; s < 4; s++) begin
        runOp(0, 1'b1, 64'(srcSet[s+2]), 64'(m), 1'b0, "R7 narrow extract");
        runOp(1, 1'b1, 64'(srcSet[s+2]), 64'(m), 1'b0, "R7 narrow deposit");
      end
    // R3 R4 zero-high over every index
    for (int i = 0; i < 256; i++)
      for (int s = 1; s < 4; s++) begin
        runOp(2, 1'b0, 64'(srcSet[s]), 64'(i), 1'b0, "R3 R4 zero-high");
        runOp(2, 1'b1, 64'(srcSet[s]), 64'(i), 1'b0, "R7 R4 narrow zero-high");
      end
    // R6 opcode 3
    runOp(3, 1'b0, 64'hFF, 64'hFF, 1'b0, "R6 opcode 3");

    // wide directed cases
    runOp(0, 1'b0, 64'hF0F0_1234_DEAD_BEEF, 64'h1000_0000_0000_00A4, 1'b1, "R1 wide extract");
    runOp(1, 1'b0, 64'h0000_0000_0000_000B, 64'h1000_0000_0000_00A4, 1'b1, "R2 wide deposit");
    runOp(0, 1'b0, 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R1 wide full mask");
    runOp(1, 1'b0, 64'hCAFE_F00D_1357_9BDF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R2 wide full mask");
    runOp(0, 1'b1, 64'hFFFF_FFFF_0F0F_0F0F, 64'hFFFF_FFFF_00FF_FF00, 1'b1, "R7 wide narrow extract");
    runOp(1, 1'b1, 64'hFFFF_FFFF_0000_FFFF, 64'hAAAA_AAAA_5555_5555, 1'b1, "R7 wide narrow deposit");
    runOp(2, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FF00_0000_0105, 1'b1, "R4 wide index low byte");
    runOp(2, 1'b0, 64'h8123_4567_89AB_CDEF, 64'd64, 1'b1, "R4 wide index at width");
    runOp(2, 1'b0, 64'h8123_4567_89AB_CDEF, 64'd200, 1'b1, "R4 wide index above width");
    runOp(2, 1'b1, 64'h8123_4567_89AB_CDEF, 64'd40, 1'b1, "R7 R4 wide narrow index");
    runOp(0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 1'b1, "R6 R7 upper mask only");

    // R8 start while busy is ignored, result then held
    @(negedge clk);
    opcode = 2'd0; narrow = 1'b0; srcIn = 64'hA5; maskIn = 64'hFF; startS = 1'b1;
    @(negedge clk);
    startS = 1'b0;
    lat = 1;
    @(negedge clk);
    lat++;
    opcode = 2'd1; srcIn = 64'h00; maskIn = 64'h01; startS = 1'b1;
    @(negedge clk);
    lat++;
    startS = 1'b0;
    while (!doneS && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check(resS == 8'hA5, "R8 start during busy ignored", 64'(resS), 64'hA5);
    check(lat == 9, "R8 latency unchanged", 64'(lat), 64'd9);
    held = 64'(resS);
    repeat (6) @(negedge clk);
    check(64'(resS) == held && !busyS && !doneS, "R8 result held", 64'(resS), held);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule